// File: doc/BRIEF.md
# Paged Indirect Register Access Target

This block sits on the switch side of a management link and lets a host reach wide internal registers through a narrow 16-bit register window. The host sees 32 management register numbers. Three kinds of them matter. A page-select register holds an 8-bit page number and an enable flag. A command register holds an 8-bit offset and two opcode bits. Four 16-bit data windows together hold one 64-bit value. Every other register number reads as zero and ignores writes.

A host access works in this order. The host sets the page and turns its enable flag on. For a write it first stages the 64-bit value in the windows. It then writes the command register with the offset and an opcode. The block starts one access on its internal bus, which has an 8-bit page, an 8-bit offset and 64-bit data. While that access is in flight the opcode bits read back as set. They clear by themselves when the access completes, so the host polls the command register to learn when it is done. When a read completes, all four windows are reloaded with the returned value.

Inside the block the wide register file is a small memory with a configurable access latency. The page and offset are truncated to the memory's index width.

The sequencer has three states:
- ST_IDLE: no access is pending.
- ST_ISSUE: the request is presented to the store for one cycle.
- ST_WAIT: the block waits for the store's completion.

Its transitions are:
- IDLE to ISSUE on an accepted command that has a non-zero opcode.
- ISSUE to WAIT unconditionally.
- WAIT to IDLE on completion.

Top module: `mgmt_indirect_port`

## Requirements
- R1: After reset the page, enable flag, offset, opcode bits and all four windows are zero. The internal store also reads as zero at every location.
- R2: A write to register 0x10 latches the page from bits 15:8 and the enable flag from bit 0. Reading 0x10 returns {page, 7'b0, enable}.
- R3: Registers 0x18, 0x19, 0x1A and 0x1B hold bits 15:0, 31:16, 47:32 and 63:48 of the 64-bit data value. Each reads back what was last written to it or loaded into it.
- R4: A write to 0x11, with the block idle and the enable flag set, latches the offset from bits 15:8. If bits 1:0 equal 01, the four staged windows are written to the internal location at (page, offset).
- R5: If bits 1:0 of that write equal 10, the internal location at (page, offset) is read, and on completion all four windows are loaded with its value.
- R6: Reading 0x11 returns {offset, 6'b0, op}. Here op is 01 during a pending write, 10 during a pending read, and 00 when idle. The opcode bits stay set for exactly LATENCY+1 cycles after the clock edge that accepts the command, then clear by themselves.
- R7: A write to 0x11 while the enable flag is clear is ignored. It starts no access and leaves the offset unchanged.
- R8: A write to 0x11 while an access is pending is ignored. It starts no second access and leaves the offset unchanged.
- R9: A command with bits 1:0 equal to 11 is carried out as a read and shows op = 10 while it is pending.
- R10: Register numbers other than 0x10, 0x11 and 0x18 to 0x1B read as 0, and writes to them change no register.
- R11: While the read strobe is low the read data output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mgmt_wr_en | input | 1 | Write strobe for one decoded management write, one cycle |
| mgmt_rd_en | input | 1 | Read strobe; gates the read data |
| mgmt_regnum | input | 5 | Management register number |
| mgmt_wdata | input | 16 | Write data |
| mgmt_rdata | output | 16 | Read data for mgmt_regnum, combinational |

## Verification
The main function is exercised with random write and read commands over pages 0 to 3 and offsets 0 to 7, each carrying random 64-bit data. Because these addresses never alias in the default store, a write landing at the wrong page, the wrong offset or in the wrong slice order shows up on the later read-back. Every command is polled until its opcode bits clear, and the count of set polls must equal LATENCY+1, which separates a correct pending window from one that is too short or never clears. Directed cases then cover the following, each judged from register readback alone:
- a command with the enable flag clear;
- a second command arriving while one is in flight;
- a command with both opcode bits set;
- writes to unmapped register numbers;
- the read strobe held low.

// File: rtl/mgmt_ind_pkg.sv
package mgmt_ind_pkg;
    localparam int REG_W  = 16;
    localparam int N_WIN  = 4;
    localparam int DATA_W = REG_W * N_WIN;
    localparam int RN_W   = 5;

    localparam logic [RN_W-1:0] RN_PAGE = 5'h10;
    localparam logic [RN_W-1:0] RN_CMD  = 5'h11;
    localparam logic [RN_W-1:0] RN_WIN0 = 5'h18;

    localparam logic [1:0] OP_WRITE = 2'b01;
    localparam logic [1:0] OP_READ  = 2'b10;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_ISSUE = 2'd1,
        ST_WAIT  = 2'd2
    } seq_state_t;
endpackage

// File: rtl/mgmt_win_regs.sv
module mgmt_win_regs
    import mgmt_ind_pkg::*;
(
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   wr_en,
    input  logic [RN_W-1:0]        regnum,
    input  logic [REG_W-1:0]       wdata,
    input  logic                   load_en,
    input  logic [DATA_W-1:0]      load_data,
    output logic [7:0]             page,
    output logic                   page_en,
    output logic [N_WIN-1:0][REG_W-1:0] win_q
);
    logic unused_pg_bits;
    assign unused_pg_bits = ^wdata[7:1];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            page    <= '0;
            page_en <= 1'b0;
        end else if (wr_en && regnum == RN_PAGE) begin
            page    <= wdata[15:8];
            page_en <= wdata[0];
        end
    end

    for (genvar g = 0; g < N_WIN; g++) begin : g_win
        localparam logic [RN_W-1:0] WN = RN_WIN0 + RN_W'(g);
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                win_q[g] <= '0;
            end else if (load_en) begin
                win_q[g] <= load_data[g*REG_W +: REG_W];
            end else if (wr_en && regnum == WN) begin
                win_q[g] <= wdata;
            end
        end
    end
endmodule

// File: rtl/mgmt_cmd_fsm.sv
module mgmt_cmd_fsm
    import mgmt_ind_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [RN_W-1:0]  regnum,
    input  logic [REG_W-1:0] wdata,
    input  logic             page_en,
    input  logic [7:0]       page,
    input  logic             ack,
    output seq_state_t       state,
    output logic             pending,
    output logic [1:0]       op_bits,
    output logic [7:0]       cmd_ofs,
    output logic [7:0]       op_page,
    output logic             op_is_wr,
    output logic             req,
    output logic             load_en
);
    seq_state_t state_nx;
    logic       cmd_hit;
    logic       start;
    logic       unused_cmd_bits;

    assign unused_cmd_bits = ^wdata[7:2];
    assign cmd_hit = wr_en && (regnum == RN_CMD) && page_en && (state == ST_IDLE);
    assign start   = cmd_hit && (wdata[1:0] != 2'b00);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
        end else begin
            state <= state_nx;
        end
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (start) state_nx = ST_ISSUE;
            ST_ISSUE: state_nx = ST_WAIT;
            ST_WAIT:  if (ack) state_nx = ST_IDLE;
            default:  state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cmd_ofs  <= '0;
            op_page  <= '0;
            op_is_wr <= 1'b0;
        end else if (cmd_hit) begin
            cmd_ofs <= wdata[15:8];
            if (start) begin
                op_page  <= page;
                op_is_wr <= (wdata[1:0] == OP_WRITE);
            end
        end
    end

    always_comb begin
        req     = 1'b0;
        pending = 1'b0;
        load_en = 1'b0;
        op_bits = 2'b00;
        unique case (state)
            ST_IDLE: begin
            end
            ST_ISSUE: begin
                req     = 1'b1;
                pending = 1'b1;
                op_bits = op_is_wr ? OP_WRITE : OP_READ;
            end
            ST_WAIT: begin
                pending = 1'b1;
                op_bits = op_is_wr ? OP_WRITE : OP_READ;
                load_en = ack && !op_is_wr;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/mgmt_reg_store.sv
module mgmt_reg_store
    import mgmt_ind_pkg::*;
#(
    parameter int LATENCY   = 6,
    parameter int PAGE_BITS = 2,
    parameter int OFS_BITS  = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req,
    input  logic              we,
    input  logic [7:0]        page,
    input  logic [7:0]        ofs,
    input  logic [DATA_W-1:0] wdata,
    output logic              ack,
    output logic [DATA_W-1:0] rdata
);
    localparam int IDX_W = PAGE_BITS + OFS_BITS;
    localparam int DEPTH = 1 << IDX_W;
    localparam int CW    = $clog2(LATENCY + 1);

    logic [DATA_W-1:0] mem [DEPTH];
    logic [IDX_W-1:0]  idx_q;
    logic              we_q;
    logic [DATA_W-1:0] wd_q;
    logic [CW-1:0]     cnt;
    logic              unused_addr_hi;

    assign unused_addr_hi = ^{page[7:PAGE_BITS], ofs[7:OFS_BITS]};
    assign ack   = (cnt == CW'(1));
    assign rdata = mem[idx_q];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt   <= '0;
            idx_q <= '0;
            we_q  <= 1'b0;
            wd_q  <= '0;
        end else if (req) begin
            cnt   <= CW'(LATENCY);
            idx_q <= {page[PAGE_BITS-1:0], ofs[OFS_BITS-1:0]};
            we_q  <= we;
            wd_q  <= wdata;
        end else if (cnt != '0) begin
            cnt <= cnt - CW'(1);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem[i] <= '0;
        end else if (ack && we_q) begin
            mem[idx_q] <= wd_q;
        end
    end
endmodule

// File: rtl/mgmt_indirect_port.sv
module mgmt_indirect_port
    import mgmt_ind_pkg::*;
#(
    parameter int LATENCY   = 6,
    parameter int PAGE_BITS = 2,
    parameter int OFS_BITS  = 3
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        mgmt_wr_en,
    input  logic        mgmt_rd_en,
    input  logic [4:0]  mgmt_regnum,
    input  logic [15:0] mgmt_wdata,
    output logic [15:0] mgmt_rdata
);
    logic [7:0]              page;
    logic                    page_en;
    logic [N_WIN-1:0][REG_W-1:0] win_q;
    seq_state_t              state;
    logic                    pending;
    logic [1:0]              op_bits;
    logic [7:0]              cmd_ofs;
    logic [7:0]              op_page;
    logic                    op_is_wr;
    logic                    req;
    logic                    load_en;
    logic                    ack;
    logic [DATA_W-1:0]       st_rdata;
    logic [REG_W-1:0]        rd_mux;

    mgmt_win_regs u_win (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (mgmt_wr_en),
        .regnum    (mgmt_regnum),
        .wdata     (mgmt_wdata),
        .load_en   (load_en),
        .load_data (st_rdata),
        .page      (page),
        .page_en   (page_en),
        .win_q     (win_q)
    );

    mgmt_cmd_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (mgmt_wr_en),
        .regnum   (mgmt_regnum),
        .wdata    (mgmt_wdata),
        .page_en  (page_en),
        .page     (page),
        .ack      (ack),
        .state    (state),
        .pending  (pending),
        .op_bits  (op_bits),
        .cmd_ofs  (cmd_ofs),
        .op_page  (op_page),
        .op_is_wr (op_is_wr),
        .req      (req),
        .load_en  (load_en)
    );

    mgmt_reg_store #(
        .LATENCY   (LATENCY),
        .PAGE_BITS (PAGE_BITS),
        .OFS_BITS  (OFS_BITS)
    ) u_store (
        .clk   (clk),
        .rst_n (rst_n),
        .req   (req),
        .we    (op_is_wr),
        .page  (op_page),
        .ofs   (cmd_ofs),
        .wdata (win_q),
        .ack   (ack),
        .rdata (st_rdata)
    );

    always_comb begin
        rd_mux = '0;
        case (mgmt_regnum)
            RN_PAGE:          rd_mux = {page, 7'b0, page_en};
            RN_CMD:           rd_mux = {cmd_ofs, 6'b0, op_bits};
            RN_WIN0:          rd_mux = win_q[0];
            RN_WIN0 + 5'd1:   rd_mux = win_q[1];
            RN_WIN0 + 5'd2:   rd_mux = win_q[2];
            RN_WIN0 + 5'd3:   rd_mux = win_q[3];
            default:          rd_mux = '0;
        endcase
    end

    assign mgmt_rdata = mgmt_rd_en ? rd_mux : '0;
endmodule

// File: rtl/mgmt_indirect_port_chk.sv
module mgmt_indirect_port_chk
    import mgmt_ind_pkg::*;
(
    input logic        clk,
    input logic        rst_n,
    input logic        wr_en,
    input logic        rd_en,
    input logic [4:0]  regnum,
    input logic [15:0] wdata,
    input logic [15:0] rdata,
    input logic        page_en,
    input logic        pending,
    input logic [7:0]  cmd_ofs,
    input logic [1:0]  op_bits,
    input logic        ack,
    input seq_state_t  state
);
    logic cmd_wr;
    logic mapped;
    assign cmd_wr = wr_en && (regnum == RN_CMD);
    assign mapped = (regnum == RN_PAGE) || (regnum == RN_CMD) ||
                    (regnum[4:2] == RN_WIN0[4:2]);

    assert_start_pends_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && page_en && !pending && wdata[1:0] != 2'b00) |=> pending);

    assert_ack_in_wait_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ack |-> (state == ST_WAIT));

    assert_ack_ends_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_WAIT && ack) |=> !pending);

    assert_disabled_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !page_en && !pending) |=> (!pending && $stable(cmd_ofs)));

    assert_busy_ofs_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && $past(pending)) |-> $stable(cmd_ofs));

    assert_op_onehot_R9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(op_bits));

    assert_unmapped_zero_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && !mapped) |-> (rdata == 16'h0));

    assert_rd_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |-> (rdata == 16'h0));
endmodule

bind mgmt_indirect_port mgmt_indirect_port_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (mgmt_wr_en),
    .rd_en   (mgmt_rd_en),
    .regnum  (mgmt_regnum),
    .wdata   (mgmt_wdata),
    .rdata   (mgmt_rdata),
    .page_en (page_en),
    .pending (pending),
    .cmd_ofs (cmd_ofs),
    .op_bits (op_bits),
    .ack     (ack),
    .state   (state)
);

// File: tb/mgmt_indirect_port_test.sv
module mgmt_indirect_port_test;
    localparam int LAT = 6;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic        rd_en = 1'b0;
    logic [4:0]  regnum = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [63:0] model [32];
    logic [7:0]  sh_ofs;

    always #10 clk = ~clk;

    mgmt_indirect_port #(.LATENCY(LAT), .PAGE_BITS(2), .OFS_BITS(3)) uut (
        .clk         (clk),
        .rst_n       (rst_n),
        .mgmt_wr_en  (wr_en),
        .mgmt_rd_en  (rd_en),
        .mgmt_regnum (regnum),
        .mgmt_wdata  (wdata),
        .mgmt_rdata  (rdata)
    );

    function automatic logic [15:0] exp_page(input logic [7:0] p, input logic en);
        return {p, 7'b0, en};
    endfunction

    function automatic logic [15:0] exp_cmd(input logic [7:0] o, input logic [1:0] op);
        logic [1:0] shown;
        shown = (op == 2'b00) ? 2'b00 : ((op == 2'b01) ? 2'b01 : 2'b10);
        return {o, 6'b0, shown};
    endfunction

    function automatic int midx(input logic [7:0] p, input logic [7:0] o);
        return int'({p[1:0], o[2:0]});
    endfunction

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic mwr(input logic [4:0] r, input logic [15:0] v);
        wr_en = 1'b1; regnum = r; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic mrd(input logic [4:0] r, output logic [15:0] v);
        rd_en = 1'b1; regnum = r;
        #1 v = rdata;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic poll(output int n, output logic [15:0] first);
        logic [15:0] v;
        n = 0;
        first = '0;
        for (int k = 0; k < 64; k++) begin
            mrd(5'h11, v);
            if (k == 0) first = v;
            if (v[1:0] == 2'b00) break;
            n++;
        end
    endtask

    task automatic read_data(output logic [63:0] d);
        logic [15:0] v;
        for (int i = 0; i < 4; i++) begin
            mrd(5'h18 + 5'(i), v);
            d[16*i +: 16] = v;
        end
    endtask

    task automatic do_write(input logic [7:0] p, input logic [7:0] o, input logic [63:0] d);
        int n;
        logic [15:0] f;
        mwr(5'h10, exp_page(p, 1'b1));
        for (int i = 0; i < 4; i++) mwr(5'h18 + 5'(i), d[16*i +: 16]);
        mwr(5'h11, {o, 6'b0, 2'b01});
        sh_ofs = o;
        poll(n, f);
        chk("R6 write pending readback", 64'(f), 64'(exp_cmd(o, 2'b01)));
        chk("R6 write pending length", 64'(n), 64'(LAT + 1));
        model[midx(p, o)] = d;
    endtask

    task automatic do_read(input logic [7:0] p, input logic [7:0] o, input logic [1:0] op,
                           input string tag);
        int n;
        logic [15:0] f;
        logic [63:0] d;
        mwr(5'h10, exp_page(p, 1'b1));
        mwr(5'h11, {o, 6'b0, op});
        sh_ofs = o;
        poll(n, f);
        chk({tag, " pending readback"}, 64'(f), 64'(exp_cmd(o, 2'b10)));
        chk("R6 read pending length", 64'(n), 64'(LAT + 1));
        read_data(d);
        chk({tag, " loaded data"}, d, model[midx(p, o)]);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired actual=running expected=finished");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [15:0] v;
        logic [63:0] d;
        int n;
        void'($urandom(32'h5eed_0b53));
        for (int i = 0; i < 32; i++) model[i] = '0;
        sh_ofs = '0;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 reset state
        mrd(5'h10, v); chk("R1 page after reset", 64'(v), 64'h0);
        mrd(5'h11, v); chk("R1 cmd after reset", 64'(v), 64'h0);
        read_data(d);  chk("R1 windows after reset", d, 64'h0);

        // R11 strobe low gives zero
        regnum = 5'h10; rd_en = 1'b0;
        mwr(5'h10, 16'hA501);
        regnum = 5'h10;
        #1 chk("R11 rdata with strobe low", 64'(rdata), 64'h0);
        @(negedge clk);

        // R2 page readback
        mwr(5'h10, 16'h3C00);
        mrd(5'h10, v); chk("R2 page readback disabled", 64'(v), 64'(exp_page(8'h3C, 1'b0)));
        mwr(5'h10, 16'hFFFF);
        mrd(5'h10, v); chk("R2 page readback enabled", 64'(v), 64'(exp_page(8'hFF, 1'b1)));

        // R3 window slices
        mwr(5'h18, 16'h1111); mwr(5'h19, 16'h2222);
        mwr(5'h1A, 16'h3333); mwr(5'h1B, 16'h4444);
        read_data(d); chk("R3 window slice order", d, 64'h4444_3333_2222_1111);

        // R4 / R5 directed
        do_write(8'd1, 8'd2, 64'hDEAD_BEEF_0123_4567);
        do_write(8'd3, 8'd7, 64'hFFFF_0000_FFFF_0001);
        do_read(8'd1, 8'd2, 2'b10, "R5 directed read");
        do_read(8'd0, 8'd0, 2'b10, "R5 unwritten read");

        // R4 / R5 random mix
        for (int t = 0; t < 40; t++) begin
            logic [7:0] p;
            logic [7:0] o;
            p = 8'($urandom_range(0, 3));
            o = 8'($urandom_range(0, 7));
            if ($urandom_range(0, 1) == 0)
                do_write(p, o, {$urandom(), $urandom()});
            else
                do_read(p, o, 2'b10, "R5 random read");
        end

        // R9 both opcode bits set
        do_write(8'd2, 8'd5, 64'h0A0B_0C0D_0E0F_1011);
        mwr(5'h18, 16'h0); mwr(5'h19, 16'h0); mwr(5'h1A, 16'h0); mwr(5'h1B, 16'h0);
        do_read(8'd2, 8'd5, 2'b11, "R9 dual-bit command");

        // R7 command with enable clear
        mwr(5'h10, exp_page(8'd2, 1'b0));
        mwr(5'h11, {8'd6, 6'b0, 2'b10});
        mrd(5'h11, v); chk("R7 disabled command ignored", 64'(v), 64'(exp_cmd(sh_ofs, 2'b00)));
        read_data(d); chk("R7 windows untouched", d, model[midx(8'd2, 8'd5)]);

        // R8 command while pending
        for (int i = 0; i < 4; i++) mwr(5'h18 + 5'(i), 16'h7700 + 16'(i));
        mwr(5'h10, exp_page(8'd1, 1'b1));
        mwr(5'h11, {8'd4, 6'b0, 2'b01});
        mwr(5'h11, {8'd6, 6'b0, 2'b01});
        poll(n, v);
        chk("R8 offset held during pending", 64'(v), 64'(exp_cmd(8'd4, 2'b01)));
        mrd(5'h11, v); chk("R8 offset after done", 64'(v), 64'(exp_cmd(8'd4, 2'b00)));
        model[midx(8'd1, 8'd4)] = 64'h7703_7702_7701_7700;
        do_read(8'd1, 8'd6, 2'b10, "R8 second command no effect");
        do_read(8'd1, 8'd4, 2'b10, "R8 first command done");

        // R10 unmapped registers
        read_data(d);
        mwr(5'h05, 16'hFFFF); mwr(5'h12, 16'hFFFF); mwr(5'h1F, 16'hFFFF); mwr(5'h17, 16'hFFFF);
        mrd(5'h05, v); chk("R10 unmapped 0x05 reads 0", 64'(v), 64'h0);
        mrd(5'h12, v); chk("R10 unmapped 0x12 reads 0", 64'(v), 64'h0);
        mrd(5'h1F, v); chk("R10 unmapped 0x1F reads 0", 64'(v), 64'h0);
        mrd(5'h10, v); chk("R10 page unchanged", 64'(v), 64'(exp_page(8'd1, 1'b1)));
        mrd(5'h11, v); chk("R10 cmd unchanged", 64'(v), 64'(exp_cmd(8'd4, 2'b00)));
        begin
            logic [63:0] d2;
            read_data(d2); chk("R10 windows unchanged", d2, d);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule